// File: doc/BRIEF.md
# IrDA Pulse Shaper with Line Inversion

This block sits between the serial bit stream of a UART and the physical TX and RX pins. In the transmit direction it either passes the NRZ level straight through or turns every zero bit into one short high pulse, leaving the line low for a one bit. In the receive direction it either passes the sampled level through or watches each bit window for a pulse and reports a zero for any window that held one. A polarity flip can be applied to each direction on its own, whether shaping is on or off.

A six-bit control register selects the behaviour. Pulse shaping is active only when the enable bit is set together with at least one of three width selects: 3/16 of a bit, a fixed minimum width counted in system clocks (about 1.63 us), or 1/4 of a bit. A one-cycle strobe at sixteen times the bit rate supplies the timing. Bit windows are counted from reset: a window ends on every 16th strobe, and a new mode selection is taken on at that window edge.

Top module: `irda_shaper`

## Requirements
- R1: While reset is held, ctrl_q_o reads 0, tx_pin_o is 1 and rx_nrz_o is 1, whatever the input levels.
- R2: A write (ctrl_we_i high for one cycle) stores ctrl_d_i, and ctrl_q_o returns it on the next cycle. The bit meanings are: 5 TX invert, 4 RX invert, 3 quarter-bit select, 2 fixed-width select, 1 3/16 select, 0 shaping enable.
- R3: With bit 0 clear, or bit 0 set with no width select, tx_pin_o equals tx_nrz_i one cycle later and rx_nrz_o equals rx_pin_i three cycles later. Width selects have no effect while bit 0 is clear.
- R4: Bit 5 inverts tx_pin_o in pass-through mode and in every shaping mode.
- R5: Bit 4 inverts the sampled rx_pin_i in pass-through mode and in every shaping mode.
- R6: A bit boundary is the clock in which tick16_i is high for the 16th time since reset, and every 16th tick after that. In a shaping mode, tx_nrz_i is sampled at the boundary. A 0 starts a pulse that shows on tx_pin_o from the following cycle. A 1 leaves tx_pin_o low (before inversion) for the whole bit.
- R7: In 3/16 mode (control value 0x03) the pulse lasts 3 tick periods.
- R8: In fixed-width mode (0x05) the pulse lasts SHORT_CYC clock cycles, whatever the tick rate.
- R9: In quarter-bit mode (0x09) the pulse lasts 4 tick periods.
- R10: When more than one width select is set, quarter-bit wins over fixed-width, and fixed-width wins over 3/16.
- R11: A change of mode (entering, leaving or switching shaping) takes effect only at the next bit boundary. Until then the previous mode keeps driving tx_pin_o.
- R12: In a shaping mode, rx_nrz_o changes only at a bit boundary. It becomes 0 if the inverted-as-configured RX level was high in any cycle of the window that just ended, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | One-cycle strobe at 16x the bit rate |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_d_i | input | 6 | Control register write data |
| ctrl_q_o | output | 6 | Control register contents |
| tx_nrz_i | input | 1 | NRZ transmit bit from the UART |
| tx_pin_o | output | 1 | Physical TX line |
| rx_pin_i | input | 1 | Physical RX line |
| rx_nrz_o | output | 1 | Recovered NRZ receive bit to the UART |

## Verification
The hardest case to reach is a control write that lands in the middle of a bit. The old mode must keep driving the line until the window edge, and only then may the new pulse width appear. The bench rebuilds the boundary position from its own count of the tick strobes it issues. It writes the control register well inside a window, toggles tx_nrz_i and checks that the line still follows it as NRZ. It then measures the first pulse after the boundary. Receive decoding is driven the same way: a short pulse is placed in the middle of a window, the bench checks that the output holds until the boundary, and then checks that it falls.

// File: rtl/irda_pkg.sv
package irda_pkg;

  typedef enum logic [1:0] {
    MODE_NRZ     = 2'd0,
    MODE_SIR     = 2'd1,
    MODE_SHORT   = 2'd2,
    MODE_QUARTER = 2'd3
  } mode_e;

  // packed MSB first: tx_inv is bit 5, en is bit 0
  typedef struct packed {
    logic tx_inv;
    logic rx_inv;
    logic quarter;
    logic shortp;
    logic sir;
    logic en;
  } ctrl_t;

  function automatic mode_e decode_mode(ctrl_t c);
    mode_e m;
    if (!c.en)          m = MODE_NRZ;
    else if (c.quarter) m = MODE_QUARTER;
    else if (c.shortp)  m = MODE_SHORT;
    else if (c.sir)     m = MODE_SIR;
    else                m = MODE_NRZ;
    return m;
  endfunction

endpackage

// File: rtl/irda_bit_timer.sv
module irda_bit_timer #(
  parameter int OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic bit_start_o
);
  localparam int PH_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

  logic [PH_W-1:0] phase_q;

  assign bit_start_o = tick_i && (phase_q == PH_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else if (tick_i) begin
      phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
    end
  end

  AST_PHASE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(phase_q)); // R6
  AST_PHASE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_start_o |=> (phase_q == '0) && !bit_start_o); // R6

endmodule

// File: rtl/irda_tx_shaper.sv
module irda_tx_shaper
  import irda_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int SHORT_CYC = 82
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  bit_start_i,
  input  mode_e mode_nxt_i,
  input  mode_e mode_q_i,
  input  logic  tx_nrz_i,
  input  logic  tx_inv_i,
  output logic  tx_pin_o
);
  localparam int SIR_TICKS = (3 * OVS) / 16;
  localparam int QTR_TICKS = OVS / 4;
  localparam int MAX_CNT   = (SHORT_CYC > QTR_TICKS) ? SHORT_CYC : QTR_TICKS;
  localparam int CNT_W     = $clog2(MAX_CNT + 1);

  logic             pulse_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic             step;

  always_comb begin
    unique case (mode_nxt_i)
      MODE_SIR:     load_val = CNT_W'(SIR_TICKS);
      MODE_SHORT:   load_val = CNT_W'(SHORT_CYC);
      MODE_QUARTER: load_val = CNT_W'(QTR_TICKS);
      default:      load_val = '0;
    endcase
  end

  // fixed-width mode counts clocks, the others count ticks
  assign step = (mode_q_i == MODE_SHORT) || tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      cnt_q   <= '0;
    end else if (bit_start_i) begin
      if ((mode_nxt_i != MODE_NRZ) && !tx_nrz_i) begin
        pulse_q <= 1'b1;
        cnt_q   <= load_val;
      end else begin
        pulse_q <= 1'b0;
        cnt_q   <= '0;
      end
    end else if (pulse_q && step) begin
      if (cnt_q == CNT_W'(1)) pulse_q <= 1'b0;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_pin_o <= 1'b1;
    else         tx_pin_o <= ((mode_q_i == MODE_NRZ) ? tx_nrz_i : pulse_q) ^ tx_inv_i;
  end

  AST_NO_PULSE_ON_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_start_i && tx_nrz_i |=> !pulse_q); // R6
  AST_PULSE_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_start_i && !tx_nrz_i && (mode_nxt_i != MODE_NRZ) |=> pulse_q); // R6
  AST_NO_PULSE_IN_NRZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q_i == MODE_NRZ) |-> !pulse_q); // R3
  AST_TICK_PULSE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q && (mode_q_i != MODE_SHORT) |-> cnt_q <= CNT_W'(QTR_TICKS)); // R9
  AST_PULSE_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_q && !bit_start_i |=> !pulse_q); // R6

endmodule

// File: rtl/irda_rx_decoder.sv
module irda_rx_decoder
  import irda_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  bit_start_i,
  input  mode_e mode_q_i,
  input  logic  rx_pin_i,
  input  logic  rx_inv_i,
  output logic  rx_nrz_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  logic                   seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_pin_i};
  end

  assign rx_s = sync_q[SYNC_STAGES-1] ^ rx_inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_nrz_o <= 1'b1;
      seen_q   <= 1'b0;
    end else if (mode_q_i == MODE_NRZ) begin
      rx_nrz_o <= rx_s;
      seen_q   <= 1'b0;
    end else if (bit_start_i) begin
      rx_nrz_o <= ~(seen_q | rx_s);
      seen_q   <= 1'b0;
    end else if (rx_s) begin
      seen_q   <= 1'b1;
    end
  end

  AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q_i != MODE_NRZ) && !bit_start_i |=> $stable(rx_nrz_o)); // R12
  AST_RX_PULSE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q_i != MODE_NRZ) && bit_start_i && seen_q |=> !rx_nrz_o); // R12

endmodule

// File: rtl/irda_shaper.sv
module irda_shaper
  import irda_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int SHORT_CYC = 82
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick16_i,
  input  logic       ctrl_we_i,
  input  logic [5:0] ctrl_d_i,
  output logic [5:0] ctrl_q_o,
  input  logic       tx_nrz_i,
  output logic       tx_pin_o,
  input  logic       rx_pin_i,
  output logic       rx_nrz_o
);
  ctrl_t ctrl_q;
  mode_e mode_q;
  mode_e mode_nxt;
  logic  bit_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_t'(ctrl_d_i);
  end

  assign ctrl_q_o = ctrl_q;
  assign mode_nxt = decode_mode(ctrl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= MODE_NRZ;
    else if (bit_start) mode_q <= mode_nxt;
  end

  irda_bit_timer #(.OVS(OVS)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick16_i),
    .bit_start_o (bit_start)
  );

  irda_tx_shaper #(.OVS(OVS), .SHORT_CYC(SHORT_CYC)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick16_i),
    .bit_start_i (bit_start),
    .mode_nxt_i  (mode_nxt),
    .mode_q_i    (mode_q),
    .tx_nrz_i    (tx_nrz_i),
    .tx_inv_i    (ctrl_q.tx_inv),
    .tx_pin_o    (tx_pin_o)
  );

  irda_rx_decoder #(.SYNC_STAGES(2)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_start_i (bit_start),
    .mode_q_i    (mode_q),
    .rx_pin_i    (rx_pin_i),
    .rx_inv_i    (ctrl_q.rx_inv),
    .rx_nrz_o    (rx_nrz_o)
  );

  AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> ctrl_q_o == $past(ctrl_d_i)); // R2
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(ctrl_q_o)); // R2
  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_start |=> $stable(mode_q)); // R11

endmodule

// File: tb/sim_irda_shaper.sv
module sim_irda_shaper;
  localparam int SHORT_CYC = 82;
  localparam int TICK_DIV  = 8;   // 128 clocks per bit

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [5:0] ctrl_d = '0;
  logic [5:0] ctrl_q;
  logic       tx_nrz = 1'b1;
  logic       tx_pin;
  logic       rx_pin = 1'b1;
  logic       rx_nrz;

  int total = 0;
  int fails = 0;

  logic [2:0] div_q;
  logic [3:0] bphase;
  logic       bnd_now;

  always #10 clk = ~clk;

  irda_shaper #(.OVS(16), .SHORT_CYC(SHORT_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick16),
    .ctrl_we_i(ctrl_we), .ctrl_d_i(ctrl_d), .ctrl_q_o(ctrl_q),
    .tx_nrz_i(tx_nrz), .tx_pin_o(tx_pin),
    .rx_pin_i(rx_pin), .rx_nrz_o(rx_nrz)
  );

  // tick strobe and the bench's own count of bit boundaries
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; tick16 <= 1'b0; bphase <= '0;
    end else begin
      div_q  <= div_q + 1'b1;
      tick16 <= (div_q == 3'(TICK_DIV - 1));
      if (tick16) bphase <= bphase + 1'b1;
    end
  end
  assign bnd_now = tick16 && (bphase == 4'd15);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ctrl(logic [5:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_d = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wait_bnd();
    do @(negedge clk); while (!bnd_now);
    @(posedge clk);
  endtask

  // cycles in the next 120 where tx_pin differs from its idle level
  task automatic measure(input logic inv, output int w);
    w = 0;
    wait_bnd();
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (tx_pin != inv) w++;
    end
  endtask

  task automatic t_reset();
    tx_nrz = 1'b0; rx_pin = 1'b0;
    cyc(3);
    chk("R1 ctrl", int'(ctrl_q), 0);
    chk("R1 tx_pin", int'(tx_pin), 1);
    chk("R1 rx_nrz", int'(rx_nrz), 1);
    tx_nrz = 1'b1; rx_pin = 1'b1;
    rst_n = 1'b1;
    cyc(2);
  endtask

  task automatic t_ctrl_reg();
    write_ctrl(6'h3F);
    chk("R2 all ones", int'(ctrl_q), 'h3F);
    write_ctrl(6'h2A);
    chk("R2 pattern", int'(ctrl_q), 'h2A);
    write_ctrl(6'h00);
    chk("R2 clear", int'(ctrl_q), 0);
  endtask

  task automatic t_nrz_pass();
    write_ctrl(6'h0E);  // width selects without enable
    tx_nrz = 1'b0; cyc(1);
    chk("R3 tx low", int'(tx_pin), 0);
    tx_nrz = 1'b1; cyc(1);
    chk("R3 tx high", int'(tx_pin), 1);
    rx_pin = 1'b0; cyc(4);
    chk("R3 rx low", int'(rx_nrz), 0);
    write_ctrl(6'h01);  // enable alone
    wait_bnd(); cyc(2);
    tx_nrz = 1'b0; cyc(1);
    chk("R3 en only tx", int'(tx_pin), 0);
    rx_pin = 1'b1; cyc(4);
    chk("R3 en only rx", int'(rx_nrz), 1);
    tx_nrz = 1'b1;
  endtask

  task automatic t_tx_inv();
    write_ctrl(6'h20);
    tx_nrz = 1'b1; cyc(1);
    chk("R4 nrz inv high", int'(tx_pin), 0);
    tx_nrz = 1'b0; cyc(1);
    chk("R4 nrz inv low", int'(tx_pin), 1);
    tx_nrz = 1'b1;
  endtask

  task automatic t_rx_inv();
    write_ctrl(6'h10);
    rx_pin = 1'b1; cyc(4);
    chk("R5 nrz inv high", int'(rx_nrz), 0);
    rx_pin = 1'b0; cyc(4);
    chk("R5 nrz inv low", int'(rx_nrz), 1);
    rx_pin = 1'b0;
  endtask

  task automatic t_sir();
    int w;
    write_ctrl(6'h03);
    tx_nrz = 1'b0;
    measure(1'b0, w);
    chk("R7 3/16 width", w, 3 * TICK_DIV);
    tx_nrz = 1'b1;
    measure(1'b0, w);
    chk("R6 one bit no pulse", w, 0);
    tx_nrz = 1'b0;
    write_ctrl(6'h23);
    measure(1'b1, w);
    chk("R4 inverted pulse width", w, 3 * TICK_DIV);
  endtask

  task automatic t_short();
    int w;
    write_ctrl(6'h05);
    tx_nrz = 1'b0;
    measure(1'b0, w);
    chk("R8 fixed width", w, SHORT_CYC);
  endtask

  task automatic t_quarter();
    int w;
    write_ctrl(6'h09);
    tx_nrz = 1'b0;
    measure(1'b0, w);
    chk("R9 quarter width", w, 4 * TICK_DIV);
  endtask

  task automatic t_priority();
    int w;
    write_ctrl(6'h0F);
    measure(1'b0, w);
    chk("R10 quarter wins", w, 4 * TICK_DIV);
    write_ctrl(6'h07);
    measure(1'b0, w);
    chk("R10 fixed over 3/16", w, SHORT_CYC);
  endtask

  task automatic t_mode_boundary();
    int w;
    write_ctrl(6'h00);
    tx_nrz = 1'b0;
    wait_bnd(); cyc(20);
    write_ctrl(6'h03);
    tx_nrz = 1'b1; cyc(1);
    chk("R11 old mode still nrz high", int'(tx_pin), 1);
    tx_nrz = 1'b0; cyc(1);
    chk("R11 old mode still nrz low", int'(tx_pin), 0);
    measure(1'b0, w);
    chk("R11 new width at boundary", w, 3 * TICK_DIV);
    tx_nrz = 1'b1;
  endtask

  task automatic rx_window(logic idle, string tag);
    rx_pin = idle;
    wait_bnd();            // mode latched
    wait_bnd(); cyc(2);    // empty window decoded
    chk({"R12 empty window ", tag}, int'(rx_nrz), 1);
    cyc(38);
    rx_pin = ~idle; cyc(3); rx_pin = idle;
    cyc(20);
    chk({"R12 hold mid window ", tag}, int'(rx_nrz), 1);
    wait_bnd(); cyc(2);
    chk({"R12 pulse decoded ", tag}, int'(rx_nrz), 0);
    wait_bnd(); cyc(2);
    chk({"R12 next empty ", tag}, int'(rx_nrz), 1);
  endtask

  task automatic t_rx_decode();
    tx_nrz = 1'b1;
    write_ctrl(6'h03);
    rx_window(1'b0, "plain");
    write_ctrl(6'h13);  // R5 inversion with shaping
    rx_window(1'b1, "R5 inverted");
  endtask

  initial begin
    #(20 * 150000);
    total++; fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_ctrl_reg();
    t_nrz_pass();
    t_tx_inv();
    t_rx_inv();
    t_sir();
    t_short();
    t_quarter();
    t_priority();
    t_mode_boundary();
    t_rx_decode();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule